// File: doc/BRIEF.md
# SPI Master Register Front-End

This block puts a single-transaction SPI master behind a small Wishbone slave. Software loads an outgoing word, writes a one-bit arm control to launch a transfer, then collects the word shifted in from the peripheral. The transfer cannot be cut short once it has begun. A two-bit status shows whether the engine is ready to be armed or has finished. A second, blocking copy of that status holds back the bus acknowledge until the transfer is over, so one plain CPU load waits for completion without polling.

The shift engine has a parameter for the word width, for example 18 bits for a converter input or 24 bits for a converter output. It also has parameters for the idle level of the serial clock and for the half-period in system clocks. A companion conversion strobe is the inverse of the active-low select, which suits converters that sample while select is asserted.

Top module: `spiw_top`

## Requirements
- R1: After reset the status reads ready=1 and finished=0. Select is high, the serial clock sits at its idle level CPOL, ack is low and the arm register reads 0.
- R2: Registers sit at byte offsets 0x0 (status: bit0 finished, bit1 ready, other bits 0), 0x4 (arm, bit0), 0x8 (received word, read-only), 0xC (outgoing word, 32-bit read/write) and 0x10 (blocking status). A read of any other offset returns 0. A write to a read-only offset has no effect.
- R3: Writing 1 to arm while ready starts a transfer. Select goes low, status reads 00 while the transfer runs, and exactly XFER_WIDTH leading clock edges are produced. The leading edge is the one away from CPOL.
- R4: MOSI carries the low XFER_WIDTH bits of the outgoing word, MSB first. It changes only on trailing edges and is stable at each leading edge.
- R5: MISO is sampled on each leading edge, MSB first. At the end of the transfer the received word holds those bits right-aligned, with the upper bits 0.
- R6: After the last bit, select returns high and the status reads finished (01). It stays there, even if arm is written with 1 again, until arm is written with 0. The status then reads ready (10).
- R7: A write of 0 to arm during a transfer is ignored. The transfer runs to completion and the arm register still reads 1.
- R8: Writes to the outgoing word while a transfer runs are ignored, both in the readback and in the bits sent. Writes while ready are accepted.
- R9: A read of offset 0x10 returns the same two bits as offset 0x0. Its ack is withheld while both bits are 0, and follows one cycle after the request otherwise.
- R10: The conversion strobe equals the inverse of select at all times.
- R11: Every other access is acknowledged by a one-cycle ack pulse one clock after the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wbCyc | input | 1 | Bus cycle active |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | Write enable |
| wbAdr | input | ADDR_W | Byte address |
| wbDatW | input | 32 | Write data |
| wbDatR | output | 32 | Read data |
| wbAck | output | 1 | Acknowledge pulse |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiSsN | output | 1 | Active-low slave select |
| convStrobe | output | 1 | Conversion strobe, inverse of select |

## Verification
The bench aims at the blocking status read. It checks that the ack arrives only after select has risen, and that the ack comes at once when the engine is idle. A design that acked early would return 00, and one that never released would hang the bus. Disarm and outgoing-word writes are issued in the middle of a transfer. A design that aborted would give a short clock count or fall back to ready without passing through finished, and one that took the write would send or read back the new word. A re-arm issued while finished must not start a second transfer, and the received word must stay zero above the transfer width. A design with a wrong sample edge or shift order fails the random word comparisons against a slave model.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } spiwState_t;

  typedef struct packed {
    logic loadTx;
    logic start;
  } spiwStrobes_t;

  localparam logic [2:0] IDX_STATUS = 3'd0;
  localparam logic [2:0] IDX_ARM    = 3'd1;
  localparam logic [2:0] IDX_RX     = 3'd2;
  localparam logic [2:0] IDX_TX     = 3'd3;
  localparam logic [2:0] IDX_WAIT   = 3'd4;

endpackage

// File: rtl/spiw_ctrl.sv
module spiw_ctrl
  import spiw_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  input  logic [31:0]       wbDatW,
  input  logic [31:0]       toSlaveQ,
  input  logic [31:0]       fromSlaveQ,
  input  logic              xferDone,
  output logic [31:0]       wbDatR,
  output logic              wbAck,
  output spiwStrobes_t      strobes,
  output logic              statusReady,
  output logic              statusFinished
);

  localparam int IDX_W = ADDR_W - 2;

  spiwState_t state;
  logic       armBit;
  logic [IDX_W-1:0] regIdx;
  logic [1:0] statusBits;
  logic       reqValid;
  logic       holdOff;
  logic       accept;
  logic       wrAccept;
  logic       armWrite;
  logic       startXfer;
  logic       disarm;
  logic [31:0] readMux;

  assign regIdx         = wbAdr[ADDR_W-1:2];
  assign statusReady    = (state == ST_IDLE);
  assign statusFinished = (state == ST_DONE);
  assign statusBits     = {statusReady, statusFinished};

  assign reqValid  = wbCyc && wbStb && !wbAck;
  assign holdOff   = (regIdx == IDX_W'(IDX_WAIT)) && !wbWe && (statusBits == 2'b00);
  assign accept    = reqValid && !holdOff;
  assign wrAccept  = accept && wbWe;
  assign armWrite  = wrAccept && (regIdx == IDX_W'(IDX_ARM));
  assign startXfer = armWrite && wbDatW[0] && (state == ST_IDLE);
  assign disarm    = armWrite && !wbDatW[0] && (state == ST_DONE);

  always_comb begin
    strobes.start  = startXfer;
    strobes.loadTx = wrAccept && (regIdx == IDX_W'(IDX_TX)) && (state != ST_RUN);
  end

  always_comb begin
    readMux = 32'd0;
    case (regIdx)
      IDX_W'(IDX_STATUS): readMux = {30'd0, statusBits};
      IDX_W'(IDX_ARM):    readMux = {31'd0, armBit};
      IDX_W'(IDX_RX):     readMux = fromSlaveQ;
      IDX_W'(IDX_TX):     readMux = toSlaveQ;
      IDX_W'(IDX_WAIT):   readMux = {30'd0, statusBits};
      default:            readMux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbAck  <= 1'b0;
      wbDatR <= 32'd0;
    end else begin
      wbAck <= accept;
      if (accept && !wbWe) begin
        wbDatR <= readMux;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armBit <= 1'b0;
    end else if (armWrite && (state != ST_RUN)) begin
      armBit <= wbDatW[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (startXfer) state <= ST_RUN;
        ST_RUN:  if (xferDone)  state <= ST_DONE;
        ST_DONE: if (disarm)    state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spiw_datapath.sv
module spiw_datapath
  import spiw_pkg::*;
#(
  parameter int XFER_WIDTH = 24,
  parameter bit CPOL       = 1'b0,
  parameter int HALF_DIV   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  spiwStrobes_t strobes,
  input  logic [31:0]  wbDatW,
  input  logic         spiMiso,
  output logic [31:0]  toSlaveQ,
  output logic [31:0]  fromSlaveQ,
  output logic         xferDone,
  output logic         spiSck,
  output logic         spiMosi,
  output logic         spiSsN
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = (XFER_WIDTH > 1) ? $clog2(XFER_WIDTH) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(XFER_WIDTH - 1);

  logic [XFER_WIDTH-1:0] txShift;
  logic [XFER_WIDTH-1:0] rxShift;
  logic [DIV_W-1:0]      divCnt;
  logic [CNT_W-1:0]      bitCnt;
  logic                  leadNext;
  logic                  running;
  logic                  tick;

  assign running  = !spiSsN;
  assign tick     = running && (divCnt == DIV_LAST);
  assign xferDone = tick && !leadNext && (bitCnt == BIT_LAST);
  assign spiMosi  = running ? txShift[XFER_WIDTH-1] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      toSlaveQ <= 32'd0;
    end else if (strobes.loadTx) begin
      toSlaveQ <= wbDatW;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fromSlaveQ <= 32'd0;
      txShift    <= '0;
      rxShift    <= '0;
      divCnt     <= '0;
      bitCnt     <= '0;
      leadNext   <= 1'b1;
      spiSck     <= CPOL;
      spiSsN     <= 1'b1;
    end else if (strobes.start) begin
      txShift  <= toSlaveQ[XFER_WIDTH-1:0];
      rxShift  <= '0;
      divCnt   <= '0;
      bitCnt   <= '0;
      leadNext <= 1'b1;
      spiSck   <= CPOL;
      spiSsN   <= 1'b0;
    end else if (running) begin
      if (tick) begin
        divCnt <= '0;
        if (leadNext) begin
          spiSck   <= ~CPOL;
          rxShift  <= {rxShift[XFER_WIDTH-2:0], spiMiso};
          leadNext <= 1'b0;
        end else begin
          spiSck   <= CPOL;
          leadNext <= 1'b1;
          if (bitCnt == BIT_LAST) begin
            spiSsN     <= 1'b1;
            fromSlaveQ <= 32'(rxShift);
          end else begin
            txShift <= {txShift[XFER_WIDTH-2:0], 1'b0};
            bitCnt  <= bitCnt + 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spiw_top.sv
module spiw_top
  import spiw_pkg::*;
#(
  parameter int XFER_WIDTH = 24,
  parameter bit CPOL       = 1'b0,
  parameter int HALF_DIV   = 2,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [ADDR_W-1:0] wbAdr,
  input  logic [31:0]       wbDatW,
  output logic [31:0]       wbDatR,
  output logic              wbAck,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              spiSsN,
  output logic              convStrobe
);

  spiwStrobes_t strobes;
  logic [31:0]  toSlaveQ;
  logic [31:0]  fromSlaveQ;
  logic         xferDone;
  logic         statusReady;
  logic         statusFinished;

  spiw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr), .wbDatW(wbDatW),
    .toSlaveQ(toSlaveQ), .fromSlaveQ(fromSlaveQ), .xferDone(xferDone),
    .wbDatR(wbDatR), .wbAck(wbAck), .strobes(strobes),
    .statusReady(statusReady), .statusFinished(statusFinished)
  );

  spiw_datapath #(.XFER_WIDTH(XFER_WIDTH), .CPOL(CPOL), .HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .wbDatW(wbDatW), .spiMiso(spiMiso),
    .toSlaveQ(toSlaveQ), .fromSlaveQ(fromSlaveQ), .xferDone(xferDone),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiSsN(spiSsN)
  );

  assign convStrobe = ~spiSsN;

endmodule

// File: rtl/spiw_checker.sv
module spiw_checker #(
  parameter bit CPOL   = 1'b0,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wbAck,
  input logic              wbWe,
  input logic [ADDR_W-1:0] wbAdr,
  input logic [31:0]       wbDatR,
  input logic              spiSck,
  input logic              spiSsN,
  input logic              statusReady,
  input logic              statusFinished,
  input logic [31:0]       toSlaveQ
);

  logic busy;
  assign busy = !statusReady && !statusFinished;

  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    wbAck |=> !wbAck);

  p_status_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(statusReady && statusFinished));

  p_select_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (statusReady || statusFinished) |-> spiSsN);

  p_sck_idle_r1: assert property (@(posedge clk) disable iff (rst)
    spiSsN |-> (spiSck == CPOL));

  p_wait_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    (wbAck && !wbWe && (wbAdr == ADDR_W'(5'h10))) |-> (wbDatR[1:0] != 2'b00));

  p_no_abort_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || statusFinished));

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(toSlaveQ));

endmodule

bind spiw_top spiw_checker #(.CPOL(CPOL), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wbAck(wbAck), .wbWe(wbWe), .wbAdr(wbAdr),
  .wbDatR(wbDatR), .spiSck(spiSck), .spiSsN(spiSsN),
  .statusReady(statusReady), .statusFinished(statusFinished),
  .toSlaveQ(toSlaveQ)
);

// File: tb/spiw_top_test.sv
`timescale 1ns/1ps
module spiw_top_test;

  localparam int W      = 24;
  localparam bit CPOL   = 1'b0;
  localparam int ADDR_W = 5;
  localparam logic [31:0] MASK = 32'((64'd1 << W) - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [ADDR_W-1:0] wbAdr = '0;
  logic [31:0] wbDatW = '0;
  logic [31:0] wbDatR;
  logic wbAck, spiSck, spiMosi, spiMiso, spiSsN, convStrobe;

  always #5 clk = ~clk;

  spiw_top #(.XFER_WIDTH(W), .CPOL(CPOL), .HALF_DIV(2), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbAdr(wbAdr), .wbDatW(wbDatW), .wbDatR(wbDatR), .wbAck(wbAck),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiSsN(spiSsN),
    .convStrobe(convStrobe)
  );

  int total = 0;
  int bad = 0;
  int convErr = 0;
  int ackStuck = 0;
  int leadCount = 0;
  bit finished = 1'b0;

  // peripheral model
  logic [W-1:0] slvTx = '0;
  logic [W-1:0] slvRx = '0;
  logic [W-1:0] slvShift = '0;
  assign spiMiso = slvShift[W-1];

  always @(negedge spiSsN) begin
    slvShift = slvTx;
    slvRx = '0;
  end

  always @(spiSck) begin
    if (!spiSsN) begin
      if (spiSck != CPOL) begin
        slvRx = {slvRx[W-2:0], spiMosi};
        leadCount++;
      end else begin
        slvShift = {slvShift[W-2:0], 1'b0};
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && (convStrobe !== ~spiSsN)) convErr++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input logic w, input logic [31:0] d,
                        output logic [31:0] q, output int lat);
    @(negedge clk);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = w; wbAdr = a; wbDatW = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!wbAck && lat < 3000);
    q = wbDatR;
    if (!wbAck) chk(1'b0, "R9 ack timeout", 32'(lat), 32'd0);
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
    @(negedge clk);
    if (wbAck) ackStuck++;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] q; int lat;
    access(a, 1'b1, d, q, lat);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] q, output int lat);
    access(a, 1'b0, 32'd0, q, lat);
  endtask

  function automatic logic [31:0] expRx(input logic [W-1:0] s);
    return 32'(s) & MASK;
  endfunction

  initial begin
    #1_900_000;
    if (!finished) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, tx, tx2;
    int lat, leads0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(spiSsN == 1'b1, "R1 select idle", 32'(spiSsN), 32'd1);
    chk(spiSck == CPOL, "R1 sck idle", 32'(spiSck), 32'(CPOL));
    chk(wbAck == 1'b0, "R1 ack low", 32'(wbAck), 32'd0);
    rd(5'h00, q, lat);
    chk(q == 32'h2, "R1 status ready", q, 32'h2);
    chk(lat == 1, "R11 ack latency", 32'(lat), 32'd1);
    rd(5'h04, q, lat);
    chk(q == 32'h0, "R1 arm zero", q, 32'h0);

    // R2 map
    wr(5'h0C, 32'hA5C3_0F96);
    rd(5'h0C, q, lat);
    chk(q == 32'hA5C3_0F96, "R2 tx readback", q, 32'hA5C3_0F96);
    rd(5'h14, q, lat);
    chk(q == 32'h0, "R2 unmapped read", q, 32'h0);
    rd(5'h1C, q, lat);
    chk(q == 32'h0, "R2 unmapped read high", q, 32'h0);

    // R9 blocking read while ready
    rd(5'h10, q, lat);
    chk(q == 32'h2 && lat == 1, "R9 wait idle immediate", q, 32'h2);

    // random transfers: R3 R4 R5 R6 R9
    for (int i = 0; i < 14; i++) begin
      tx = $urandom();
      slvTx = W'($urandom());
      wr(5'h0C, tx);
      leads0 = leadCount;
      wr(5'h04, 32'd1);
      rd(5'h00, q, lat);
      chk(q == 32'h0, "R3 busy status", q, 32'h0);
      chk(spiSsN == 1'b0, "R3 select low", 32'(spiSsN), 32'd0);
      rd(5'h10, q, lat);
      chk(q == 32'h1 && lat > 1, "R9 wait returns finished", q, 32'h1);
      chk(spiSsN == 1'b1, "R9 ack after select high", 32'(spiSsN), 32'd1);
      chk(leadCount - leads0 == W, "R3 edge count", 32'(leadCount - leads0), 32'(W));
      chk(32'(slvRx) == (tx & MASK), "R4 mosi word", 32'(slvRx), tx & MASK);
      rd(5'h08, q, lat);
      chk(q == expRx(slvTx), "R5 rx word", q, expRx(slvTx));
      wr(5'h04, 32'd0);
      rd(5'h00, q, lat);
      chk(q == 32'h2, "R6 back to ready", q, 32'h2);
    end

    // R5 received word write ignored, upper bits zero
    slvTx = {W{1'b1}};
    wr(5'h04, 32'd1);
    rd(5'h10, q, lat);
    rd(5'h08, q, lat);
    chk(q == MASK, "R5 upper bits zero", q, MASK);
    wr(5'h08, 32'h1234_5678);
    rd(5'h08, q, lat);
    chk(q == MASK, "R5 rx write ignored", q, MASK);

    // R6 finished held, re-arm ignored
    repeat (10) @(negedge clk);
    rd(5'h00, q, lat);
    chk(q == 32'h1, "R6 finished held", q, 32'h1);
    leads0 = leadCount;
    wr(5'h04, 32'd1);
    repeat (20) @(negedge clk);
    rd(5'h00, q, lat);
    chk(q == 32'h1 && spiSsN && leadCount == leads0, "R6 rearm while finished", q, 32'h1);
    wr(5'h04, 32'd0);
    rd(5'h00, q, lat);
    chk(q == 32'h2, "R6 disarm to ready", q, 32'h2);

    // R7 disarm during transfer ignored
    slvTx = W'($urandom());
    leads0 = leadCount;
    wr(5'h04, 32'd1);
    repeat (20) @(negedge clk);
    wr(5'h04, 32'd0);
    rd(5'h00, q, lat);
    chk(q == 32'h0, "R7 still busy", q, 32'h0);
    rd(5'h10, q, lat);
    chk(q == 32'h1, "R7 completes", q, 32'h1);
    chk(leadCount - leads0 == W, "R7 full edge count", 32'(leadCount - leads0), 32'(W));
    rd(5'h04, q, lat);
    chk(q == 32'h1, "R7 arm still set", q, 32'h1);
    wr(5'h04, 32'd0);

    // R8 tx write during transfer ignored
    tx = $urandom();
    tx2 = ~tx;
    wr(5'h0C, tx);
    wr(5'h04, 32'd1);
    repeat (8) @(negedge clk);
    wr(5'h0C, tx2);
    rd(5'h0C, q, lat);
    chk(q == tx, "R8 readback during run", q, tx);
    rd(5'h10, q, lat);
    chk(32'(slvRx) == (tx & MASK), "R8 sent old word", 32'(slvRx), tx & MASK);
    wr(5'h04, 32'd0);
    wr(5'h0C, tx2);
    rd(5'h0C, q, lat);
    chk(q == tx2, "R8 idle write accepted", q, tx2);

    // R10, R11 aggregate
    chk(convErr == 0, "R10 conv strobe", 32'(convErr), 32'd0);
    chk(ackStuck == 0, "R11 single-cycle ack", 32'(ackStuck), 32'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule